// File: doc/BRIEF.md
# Horizontal Line Cropping Unit

This unit sits in a pixel stream that arrives one line at a time from a buffer of full source width. It keeps a contiguous horizontal window of each line and drops the pixels to its left and right; every line of the frame passes, so the frame height is unchanged. Pixels enter and leave through valid/ready handshakes. The output carries a start-of-frame flag on the first kept pixel of the first line and a line-end flag on the last kept pixel of every line. A bypass setting forwards every pixel, and software selects it when the window spans the whole source width.

Settings arrive on four configuration inputs. A geometry word holds the source width minus one in bits [31:16] and the line count minus one in bits [15:0]. A margin word holds the left margin in bits [31:16] and a right-margin code in bits [15:0]; that code equals source width − (left + window width) − 1. Both words, together with the bypass bit, are captured into live settings only when a pixel marked start-of-frame is accepted, and that pixel already uses the new values. A hold input suppresses this capture. The unit tracks its own line and column position, so frames may follow one another without a start-of-frame mark.

Top module: `hcrop`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: With bypass off, of each line only the columns x with left ≤ x ≤ width − 1 − (code + 1) reach the output, in input order with data unchanged; all other pixels are consumed and dropped.
- R3: With bypass on, every accepted pixel reaches the output unchanged.
- R4: out_eol is 1 exactly on the last kept column of each line (column width − 1 in bypass) and 0 on every other output pixel.
- R5: out_sof is 1 exactly on the first kept pixel of line 0 (column left, or 0 in bypass), and it coincides with out_eol when the window is one pixel wide.
- R6: The geometry word, margin word and bypass bit are captured on an accepted pixel with in_sof = 1 and apply to that pixel; changes at any other time have no effect on the current frame.
- R7: When cfg_hold = 1 on an accepted start-of-frame pixel, the previous live settings stay in use for the whole frame.
- R8: While out_valid = 1 and out_ready = 0, in_ready is 0 and out_valid, out_data, out_sof and out_eol hold their values into the next cycle.
- R9: After the last pixel of line (line count − 1) the position returns to column 0 of line 0 without an in_sof mark, and the next frame gets its own out_sof.
- R10: A kept pixel accepted at a clock edge is presented on the output right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 32 | [31:16] source width − 1, [15:0] line count − 1 |
| cfg_margin | input | 32 | [31:16] left margin, [15:0] right-margin code |
| cfg_bypass | input | 1 | Forward every pixel of a line |
| cfg_hold | input | 1 | Suppress capture of settings at frame start |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Unit accepts the input pixel |
| in_data | input | PIX_W | Input pixel value |
| in_sof | input | 1 | Input pixel is column 0 of line 0 |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | PIX_W | Output pixel value |
| out_sof | output | 1 | First kept pixel of the frame |
| out_eol | output | 1 | Last kept pixel of the line |

## Verification
Two things can land on the same pixel. The first is the capture of new settings, which happens on the start-of-frame pixel that the settings must already govern. The second is the pair of frame-start and line-end flags on a window one pixel wide. The bench changes the configuration in the very cycle that a start-of-frame pixel is offered, and it also runs a frame whose window is a single column. Its behavioural model evaluates that pixel with the newly captured geometry and expects both flags on one output beat, while random output stalls make sure the double-flagged beat survives backpressure.

// File: rtl/hcrop_pkg.sv
package hcrop_pkg;
    localparam int CRD_W = 16;

    typedef struct packed {
        logic [CRD_W-1:0] wmax;   // source width - 1
        logic [CRD_W-1:0] hmax;   // line count - 1
        logic [CRD_W-1:0] left;   // first kept column
        logic [CRD_W-1:0] rcode;  // right margin minus one
        logic             bypass;
    } hcrop_cfg_t;
endpackage

// File: rtl/hcrop_shadow.sv
module hcrop_shadow
    import hcrop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] cfg_size,
    input  logic [31:0] cfg_margin,
    input  logic        cfg_bypass,
    output hcrop_cfg_t  live
);
    hcrop_cfg_t fresh;
    hcrop_cfg_t act_d, act_q;

    always_comb begin
        fresh.wmax   = cfg_size[2*CRD_W-1:CRD_W];
        fresh.hmax   = cfg_size[CRD_W-1:0];
        fresh.left   = cfg_margin[2*CRD_W-1:CRD_W];
        fresh.rcode  = cfg_margin[CRD_W-1:0];
        fresh.bypass = cfg_bypass;
        act_d = act_q;
        if (load) act_d = fresh;
        live = load ? fresh : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q        <= '0;
            act_q.bypass <= 1'b1;
        end else begin
            act_q <= act_d;
        end
    end
endmodule

// File: rtl/hcrop_pos.sv
module hcrop_pos #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          restart,
    input  logic [CW-1:0] wmax,
    input  logic [CW-1:0] hmax,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y
);
    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        cur_x = restart ? '0 : pos_q.x;
        cur_y = restart ? '0 : pos_q.y;
        pos_d = pos_q;
        if (step) begin
            if (cur_x == wmax) begin
                pos_d.x = '0;
                pos_d.y = (cur_y == hmax) ? '0 : cur_y + 1'b1;
            end else begin
                pos_d.x = cur_x + 1'b1;
                pos_d.y = cur_y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/hcrop_window.sv
module hcrop_window #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] wmax,
    input  logic [CW-1:0] left,
    input  logic [CW-1:0] rcode,
    input  logic          bypass,
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    output logic          keep,
    output logic          last,
    output logic          first
);
    logic [CW-1:0] last_x;
    logic [CW-1:0] first_x;

    always_comb begin
        last_x  = bypass ? wmax : (wmax - rcode - 1'b1);
        first_x = bypass ? '0 : left;
        keep    = bypass || ((cur_x >= left) && (cur_x <= last_x));
        last    = (cur_x == last_x);
        first   = (cur_y == '0) && (cur_x == first_x);
    end
endmodule

// File: rtl/hcrop.sv
module hcrop
    import hcrop_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_size,
    input  logic [31:0]      cfg_margin,
    input  logic             cfg_bypass,
    input  logic             cfg_hold,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_sof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sof,
    output logic             out_eol
);
    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] data;
        logic             sof;
        logic             eol;
    } beat_t;

    beat_t            o_d, o_q;
    logic             acc;
    logic             load;
    hcrop_cfg_t       live;
    logic [CRD_W-1:0] cur_x, cur_y;
    logic             win_keep, win_last, win_first;

    assign in_ready = !o_q.valid || out_ready;
    assign acc      = in_valid && in_ready;
    assign load     = acc && in_sof && !cfg_hold;

    hcrop_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_size   (cfg_size),
        .cfg_margin (cfg_margin),
        .cfg_bypass (cfg_bypass),
        .live       (live)
    );

    hcrop_pos #(.CW(CRD_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (acc),
        .restart (in_valid && in_sof),
        .wmax    (live.wmax),
        .hmax    (live.hmax),
        .cur_x   (cur_x),
        .cur_y   (cur_y)
    );

    hcrop_window #(.CW(CRD_W)) u_win (
        .wmax   (live.wmax),
        .left   (live.left),
        .rcode  (live.rcode),
        .bypass (live.bypass),
        .cur_x  (cur_x),
        .cur_y  (cur_y),
        .keep   (win_keep),
        .last   (win_last),
        .first  (win_first)
    );

    always_comb begin
        o_d = o_q;
        if (o_q.valid && out_ready) o_d.valid = 1'b0;
        if (acc && win_keep) begin
            o_d.valid = 1'b1;
            o_d.data  = in_data;
            o_d.sof   = win_first;
            o_d.eol   = win_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;
    assign out_sof   = o_q.sof;
    assign out_eol   = o_q.eol;
endmodule

// File: rtl/hcrop_chk.sv
module hcrop_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             out_sof,
    input logic             out_eol,
    input logic             keep,
    input logic             last
);
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sof) && $stable(out_eol));

    p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_kept_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && keep |=> out_valid);

    p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !keep && (!out_valid || out_ready) |=> !out_valid);

    p_last_is_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && last |-> keep);
endmodule

bind hcrop hcrop_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .keep      (win_keep),
    .last      (win_last)
);

// File: tb/hcrop_tb.sv
module hcrop_tb;
    localparam int PW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [31:0]   cfg_size, cfg_margin;
    logic          cfg_bypass, cfg_hold;
    logic          in_valid, in_ready, in_sof;
    logic [PW-1:0] in_data;
    logic          out_valid, out_ready, out_sof, out_eol;
    logic [PW-1:0] out_data;

    always #10 clk = ~clk;

    hcrop #(.PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_margin(cfg_margin),
        .cfg_bypass(cfg_bypass), .cfg_hold(cfg_hold),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    typedef struct {
        logic [PW-1:0] d;
        bit            s;
        bit            e;
    } exp_t;

    exp_t          q[$];
    int            n_checks = 0, n_fails = 0;
    bit            done = 0;
    string         tag = "R1";
    bit            stall_mode = 0;
    bit            stall_prev = 0, exp_valid_next = 0;
    logic [PW-1:0] held;
    logic [31:0]   n_size = 0, n_margin = 0;
    bit            n_bypass = 0, n_hold = 0;
    int            mx = 0, my = 0, mW = 1, mH = 1, mL = 0, mR = 1;
    bit            mB = 1;
    int            pix = 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_beat(logic [PW-1:0] d, bit s);
        int first_k, last_k;
        if (s) begin
            mx = 0; my = 0;
            if (!cfg_hold) begin
                mW = int'(cfg_size[31:16]) + 1;
                mH = int'(cfg_size[15:0]) + 1;
                mL = int'(cfg_margin[31:16]);
                mR = int'(cfg_margin[15:0]) + 1;
                mB = cfg_bypass;
            end
        end
        first_k = mB ? 0 : mL;
        last_k  = mB ? mW - 1 : mW - 1 - mR;
        if (mx >= first_k && mx <= last_k) begin
            q.push_back('{d: d, s: (my == 0 && mx == first_k), e: (mx == last_k)});
            exp_valid_next = 1;
        end
        mx++;
        if (mx == mW) begin
            mx = 0; my++;
            if (my == mH) my = 0;
        end
    endtask

    task automatic step(bit v, logic [PW-1:0] d, bit s, output bit acc);
        exp_t e;
        @(negedge clk);
        in_valid = v; in_data = d; in_sof = s;
        cfg_size = n_size; cfg_margin = n_margin; cfg_bypass = n_bypass; cfg_hold = n_hold;
        out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        #2;
        if (stall_prev)
            chk(out_valid === 1'b1 && out_data === held, "R8", "held output", int'(out_data), int'(held));
        if (exp_valid_next)
            chk(out_valid === 1'b1, "R10", "valid after kept pixel", int'(out_valid), 1);
        exp_valid_next = 0;
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk(0, tag, "unexpected output", int'(out_data), 0);
            end else begin
                e = q.pop_front();
                chk(out_data === e.d, tag, "data", int'(out_data), int'(e.d));
                chk(out_eol === e.e, "R4", "line end", int'(out_eol), int'(e.e));
                chk(out_sof === e.s, "R5", "frame start", int'(out_sof), int'(e.s));
            end
        end
        stall_prev = out_valid && !out_ready;
        held = out_data;
        acc = in_valid && in_ready;
        if (acc) model_beat(d, s);
    endtask

    task automatic send_pixel(bit s);
        bit acc;
        if (stall_mode) repeat ($urandom_range(0, 2)) step(0, '0, 0, acc);
        acc = 0;
        while (!acc) step(1, PW'(pix), s, acc);
        pix++;
    endtask

    task automatic send_frame(int w, int h, bit with_sof);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                send_pixel(with_sof && x == 0 && y == 0);
    endtask

    task automatic set_cfg(int w, int h, int l, int win, bit hold);
        n_size = {16'(w - 1), 16'(h - 1)};
        n_hold = hold;
        if (win == w) begin
            n_bypass = 1; n_margin = 0;
        end else begin
            n_bypass = 0; n_margin = {16'(l), 16'(w - (l + win) - 1)};
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        bit acc;
        rst_n = 0; in_valid = 0; in_data = '0; in_sof = 0; out_ready = 1;
        cfg_size = 0; cfg_margin = 0; cfg_bypass = 0; cfg_hold = 0;
        repeat (2) @(negedge clk);
        #2;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1", "reset state", int'({out_valid, in_ready}), 1);
        @(negedge clk);
        rst_n = 1;
        #2;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1", "after reset", int'({out_valid, in_ready}), 1);

        // R2: window columns 2..6 of 8, full rate
        tag = "R2"; set_cfg(8, 3, 2, 5, 0);
        send_frame(8, 3, 1);
        // R8: same geometry under random stalls
        tag = "R8"; stall_mode = 1;
        send_frame(8, 3, 1);
        // R6: settings changed mid-frame must wait for the next frame start
        tag = "R6";
        for (int i = 0; i < 8 * 3; i++) begin
            if (i == 3) set_cfg(10, 2, 0, 10, 0);
            send_pixel(i == 0);
        end
        // R3: bypass frame
        tag = "R3";
        send_frame(10, 2, 1);
        // R7: hold keeps the bypass geometry
        tag = "R7"; set_cfg(7, 2, 5, 1, 1);
        send_frame(10, 2, 1);
        // R5: single-column window, frame start and line end on one pixel
        tag = "R5"; set_cfg(7, 2, 5, 1, 0);
        send_frame(7, 2, 1);
        // R2: window starting at column 0
        tag = "R2"; set_cfg(9, 2, 0, 7, 0);
        send_frame(9, 2, 1);
        // R9: second frame follows without a start mark; new settings ignored
        tag = "R9"; set_cfg(6, 2, 1, 3, 0);
        send_frame(6, 2, 1);
        set_cfg(6, 2, 0, 6, 0);
        send_frame(6, 2, 0);
        send_frame(6, 2, 0);

        stall_mode = 0;
        repeat (5) step(0, '0, 0, acc);
        chk(q.size() == 0, "R2", "pixels never delivered", q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule